// File: doc/BRIEF.md
# Peripheral and System Reset Controller

This block holds the reset lines for up to ninety-six peripherals and can ask the chip for a full-system reset. Software reaches it over a simple single-cycle 32-bit register bus. Three reset banks of 32 bits each drive the peripheral reset outputs directly, and a fourth, write-only software-reset register starts a timed system-reset request.

A bank bit at 1 holds its peripheral in reset, and clearing the bit releases it. Reading a bank returns the current state of its lines, so software can test whether a given line is asserted. The system-reset path is set at build time by a reset number from 1 to 4, which picks the one trigger bit that software must write. A reset number of 0 removes the path.

The system-reset pulse comes from a two-state machine. In `SR_IDLE` the output is low. A trigger write moves it to `SR_ACTIVE` (transition *fire*). There it drives the request high while a down-counter runs. When the counter reaches zero, it returns to `SR_IDLE` (transition *expire*). Triggers that arrive in `SR_ACTIVE` do not restart the counter. The address decoder classifies each request as bank 0, bank 1, bank 2, software reset, or unmapped.

Top module: `rstctl_top`

## Requirements
- R1: While `rst_n` is low and after it is released, bank 0, 1 and 2 hold BANK0_INIT, BANK1_INIT and BANK2_INIT, `sys_rst_req` is low and `rd_valid` is low.
- R2: A write (`req_valid`=1, `req_write`=1) to byte address 0x20, 0x24 or 0x34 loads bank 0, 1 or 2 with `req_wdata`. Bit j of bank i drives `periph_rst[32*i+j]`, where 1 means held in reset. The outputs change on the clock edge that accepts the write.
- R3: A read (`req_valid`=1, `req_write`=0) of a bank address sets `rd_valid` high for one cycle after the accepting edge, with `rd_data` equal to that bank's contents.
- R4: A write to byte address 0x14 with bit (2+N) of `req_wdata` set, where N is RESET_NUM in 1..4, drives `sys_rst_req` high from the accepting edge for exactly PULSE_CYCLES cycles. It then returns low by itself. With N=2, the trigger bit is bit 4.
- R5: A write to 0x14 whose trigger bit is clear starts no pulse and changes no bank. A read of 0x14 returns zero.
- R6: A trigger write that arrives while the pulse is active neither lengthens nor restarts it.
- R7: Any address other than 0x14, 0x20, 0x24 and 0x34, including addresses that are not word-aligned, reads as zero, and writes to it change no bank.
- R8: With RESET_NUM equal to 0, `sys_rst_req` never goes high, whatever is written to 0x14.
- R9: A write to one bank leaves the other two banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (8) | Byte address |
| req_wdata | input | DATA_W (32) | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | DATA_W (32) | Read data |
| periph_rst | output | 3*DATA_W (96) | Peripheral reset lines, active high |
| sys_rst_req | output | 1 | Timed system-reset request |

## Verification
Bank writes use sparse, alternating and all-ones patterns, and the bench reads back every bank after each write. A wrong offset or a leak between banks then shows up as a mismatch in a specific bank. The software-reset register gets two writes: one with every bit except the trigger bit, and one with only the trigger bit. These separate a decoder that picks the wrong bit from one that reacts to any write. A second trigger sent during an active pulse separates a machine that restarts its counter from one that ignores the trigger, because the measured pulse length differs. An instance built with reset number 0 confirms that the path is removed. Reads and writes at unmapped and misaligned addresses check that decoding uses the full address.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int NUM_BANKS  = 3;
    localparam int SWRST_OFFS = 'h14;
    localparam int BANK0_OFFS = 'h20;
    localparam int BANK1_OFFS = 'h24;
    localparam int BANK2_OFFS = 'h34;
    localparam int TRIG_BASE  = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BANK0,
        SEL_BANK1,
        SEL_BANK2,
        SEL_SWRST
    } sel_t;

    typedef enum logic [0:0] {
        SR_IDLE,
        SR_ACTIVE
    } sr_state_t;

    function automatic int bank_offset(input int idx);
        case (idx)
            0:       return BANK0_OFFS;
            1:       return BANK1_OFFS;
            default: return BANK2_OFFS;
        endcase
    endfunction

endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode
    import rstctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);

    localparam logic [ADDR_W-1:0] A_SW = ADDR_W'(SWRST_OFFS);
    localparam logic [ADDR_W-1:0] A_B0 = ADDR_W'(BANK0_OFFS);
    localparam logic [ADDR_W-1:0] A_B1 = ADDR_W'(BANK1_OFFS);
    localparam logic [ADDR_W-1:0] A_B2 = ADDR_W'(BANK2_OFFS);

    always_comb begin
        if (addr == A_B0)      sel = SEL_BANK0;
        else if (addr == A_B1) sel = SEL_BANK1;
        else if (addr == A_B2) sel = SEL_BANK2;
        else if (addr == A_SW) sel = SEL_SWRST;
        else                   sel = SEL_NONE;
    end

endmodule

// File: rtl/rstctl_bank.sv
module rstctl_bank #(
    parameter int          WIDTH = 32,
    parameter logic [31:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= INIT[WIDTH-1:0];
        else if (we) q <= wdata;
    end

    // R9: an unselected bank keeps its lines
    a_r9_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

    // R2: a selected bank takes the written value
    a_r2_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> q == $past(wdata));

endmodule

// File: rtl/rstctl_sysreset.sv
module rstctl_sysreset
    import rstctl_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic pulse_o
);

    localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES - 1);

    sr_state_t        state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SR_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            SR_IDLE: begin
                if (trig_i) begin
                    state_nx = SR_ACTIVE;
                    cnt_nx   = CNT_LOAD;
                end
            end
            SR_ACTIVE: begin
                if (cnt == '0) state_nx = SR_IDLE;
                else           cnt_nx   = cnt - 1'b1;
            end
            default: state_nx = SR_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            SR_ACTIVE: pulse_o = 1'b1;
            default:   pulse_o = 1'b0;
        endcase
    end

    // R4: a trigger seen in idle raises the request on the next cycle
    a_r4_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SR_IDLE && trig_i) |=> pulse_o);

    // R6: an exhausted count always ends the pulse, whatever the trigger does
    a_r6_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SR_ACTIVE && cnt == '0) |=> !pulse_o);

    // R5: the request never rises without a trigger
    a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(trig_i));

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int          ADDR_W       = 8,
    parameter int          DATA_W       = 32,
    parameter int          RESET_NUM    = 2,
    parameter int          PULSE_CYCLES = 16,
    parameter logic [31:0] BANK0_INIT   = 32'h0000_0000,
    parameter logic [31:0] BANK1_INIT   = 32'h0400_0000,
    parameter logic [31:0] BANK2_INIT   = 32'h0300_00F0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_wdata,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data,
    output logic [NUM_BANKS*DATA_W-1:0] periph_rst,
    output logic                        sys_rst_req
);

    localparam bit TRIG_EN  = (RESET_NUM >= 1) && (RESET_NUM <= 4);
    localparam int TRIG_BIT = TRIG_EN ? (TRIG_BASE + RESET_NUM) : 0;
    localparam logic [NUM_BANKS-1:0][31:0] INITS = {BANK2_INIT, BANK1_INIT, BANK0_INIT};

    sel_t                          sel;
    logic                          wr_en, rd_en;
    logic [NUM_BANKS-1:0]          bank_we;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q;
    logic [DATA_W-1:0]             rd_mux;
    logic                          trig;

    assign wr_en = req_valid &&  req_write;
    assign rd_en = req_valid && !req_write;

    rstctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (req_addr),
        .sel  (sel)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        localparam sel_t MY_SEL = sel_t'(i + 1);
        assign bank_we[i] = wr_en && (sel == MY_SEL);

        rstctl_bank #(.WIDTH(DATA_W), .INIT(INITS[i])) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[i]),
            .wdata (req_wdata),
            .q     (bank_q[i])
        );

        assign periph_rst[i*DATA_W +: DATA_W] = bank_q[i];
    end

    if (TRIG_EN) begin : g_trig
        assign trig = wr_en && (sel == SEL_SWRST) && req_wdata[TRIG_BIT];
    end else begin : g_notrig
        assign trig = 1'b0;
    end

    rstctl_sysreset #(.PULSE_CYCLES(PULSE_CYCLES)) u_sysreset (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (trig),
        .pulse_o (sys_rst_req)
    );

    always_comb begin
        unique case (sel)
            SEL_BANK0: rd_mux = bank_q[0];
            SEL_BANK1: rd_mux = bank_q[1];
            SEL_BANK2: rd_mux = bank_q[2];
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? rd_mux : '0;
        end
    end

    // R7: unmapped reads come back as zero
    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> (rd_valid && rd_data == '0));

    // R5: the software-reset register reads as zero
    a_r5_swrst_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_SWRST) |=> (rd_valid && rd_data == '0));

    // R3: a bank read returns that bank one cycle later
    a_r3_bank_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_BANK1) |=> (rd_data == periph_rst[DATA_W +: DATA_W]));

    // R7: writes to unmapped addresses leave every line alone
    a_r7_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=> $stable(periph_rst));

    if (!TRIG_EN) begin : g_chk_off
        // R8: a disabled path never requests a system reset
        a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
            !sys_rst_req);
    end

endmodule

// File: tb/rstctl_top_test.sv
module rstctl_top_test;

    localparam int          AW   = 8;
    localparam int          DW   = 32;
    localparam int          NPUL = 5;
    localparam logic [31:0] I0   = 32'h0000_0011;
    localparam logic [31:0] I1   = 32'h0400_0000;
    localparam logic [31:0] I2   = 32'h0300_00F0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rd_valid, off_rd_valid;
    logic [DW-1:0] rd_data, off_rd_data;
    logic [3*DW-1:0] periph_rst, off_periph_rst;
    logic          sys_rst_req, off_sys_rst_req;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] mdl [3];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    int run = 0, last_run = 0, pulses = 0;
    bit off_seen = 1'b0;

    always #2 clk = ~clk;

    rstctl_top #(.ADDR_W(AW), .DATA_W(DW), .RESET_NUM(2), .PULSE_CYCLES(NPUL),
                 .BANK0_INIT(I0), .BANK1_INIT(I1), .BANK2_INIT(I2)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .periph_rst(periph_rst), .sys_rst_req(sys_rst_req));

    rstctl_top #(.ADDR_W(AW), .DATA_W(DW), .RESET_NUM(0), .PULSE_CYCLES(NPUL),
                 .BANK0_INIT(I0), .BANK1_INIT(I1), .BANK2_INIT(I2)) uut_off (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(off_rd_valid),
        .rd_data(off_rd_data), .periph_rst(off_periph_rst), .sys_rst_req(off_sys_rst_req));

    task automatic chk(input string tag, input logic [3*DW-1:0] act, input logic [3*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3*DW-1:0] mdl_lines();
        return {mdl[2], mdl[1], mdl[0]};
    endfunction

    // Monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected read", 1, 0);
            end else begin
                chk(tag_q.pop_front(), 96'(rd_data), 96'(exp_q.pop_front()));
            end
        end
        if (sys_rst_req) run++;
        else if (run != 0) begin
            last_run = run;
            pulses++;
            run = 0;
        end
        if (off_sys_rst_req) off_seen = 1'b1;
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        case (a)
            8'h20: mdl[0] = d;
            8'h24: mdl[1] = d;
            8'h34: mdl[2] = d;
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input string tag);
        logic [DW-1:0] e;
        case (a)
            8'h20: e = mdl[0];
            8'h24: e = mdl[1];
            8'h34: e = mdl[2];
            default: e = '0;
        endcase
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic read_all(input string tag);
        bus_read(8'h20, tag);
        bus_read(8'h24, tag);
        bus_read(8'h34, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        mdl[0] = I0; mdl[1] = I1; mdl[2] = I2;
        idle(3);
        chk("R1 reset lines", periph_rst, {I2, I1, I0});
        chk("R1 reset request low", 96'(sys_rst_req), 96'(0));
        chk("R1 reset rd_valid low", 96'(rd_valid), 96'(0));
        rst_n = 1'b1;
        idle(2);
        chk("R1 lines after release", periph_rst, {I2, I1, I0});
        read_all("R3 init readback");

        bus_write(8'h20, 32'hA5A5_0F0F);
        chk("R2 bank0 lines", periph_rst, mdl_lines());
        chk("R9 other banks kept", periph_rst[95:32], {I2, I1});
        bus_write(8'h34, 32'hFFFF_FFFF);
        bus_write(8'h24, 32'h8000_0001);
        chk("R2 all lines", periph_rst, mdl_lines());
        read_all("R3 readback after writes");
        bus_write(8'h34, 32'h0000_0000);
        chk("R2 release bank2", periph_rst, mdl_lines());
        read_all("R9 readback after clear");

        bus_read(8'h14, "R5 swrst reads zero");
        bus_write(8'h14, ~32'h0000_0010);
        idle(2 * NPUL);
        chk("R5 no pulse without trigger bit", 96'(pulses), 96'(0));
        chk("R5 banks unchanged", periph_rst, mdl_lines());

        bus_write(8'h14, 32'h0000_0010);
        idle(2 * NPUL);
        chk("R4 pulse count", 96'(pulses), 96'(1));
        chk("R4 pulse length", 96'(last_run), 96'(NPUL));

        bus_write(8'h14, 32'h0000_0010);
        idle(1);
        bus_write(8'h14, 32'h0000_0010);
        idle(2 * NPUL);
        chk("R6 retrigger count", 96'(pulses), 96'(2));
        chk("R6 retrigger length", 96'(last_run), 96'(NPUL));

        bus_read(8'h28, "R7 unmapped read 0x28");
        bus_read(8'h00, "R7 unmapped read 0x00");
        bus_read(8'h22, "R7 misaligned read 0x22");
        bus_write(8'h28, 32'hFFFF_FFFF);
        bus_write(8'h21, 32'hFFFF_FFFF);
        chk("R7 unmapped writes ignored", periph_rst, mdl_lines());
        read_all("R7 readback after unmapped writes");

        chk("R8 disabled instance silent", 96'(off_seen), 96'(0));
        chk("R8 disabled instance banks", off_periph_rst, mdl_lines());
        idle(3);
        chk("R3 scoreboard drained", 96'(exp_q.size()), 96'(0));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule